// File: doc/BRIEF.md
# Cache Maintenance Engine

This block accepts maintenance commands through a small register window and applies them to the tag, valid and dirty state of a set-associative cache. Three operations are provided. Clean writes a dirty line back and keeps it resident. Invalidate drops lines without writing them back. Clean-and-invalidate writes a dirty line back and then drops it. A command targets one of three things: a single line found by physical address, a single line named by set and way, or a mask of whole ways.

A line that is valid and dirty is handed to the next memory level over a valid/ready write-back port, and the engine waits until the write is accepted. Whole-way commands scan the cache in the background. The selected ways stay closed to allocation until the scan ends, and software polls the command register to see when it has finished. The tag state is held inside the block. A fill port places lines into it and a probe port reads any single line.

Top module: `cmo_engine`

## Requirements
- R1: After reset, busy, wb_valid_o and lock_mask_o are low, reg_rdata_o is zero and every line reads invalid and clean on the probe port.
- R2: A write starts a command only at these offsets: 0x77C invalidate by way mask, 0x7B0 clean by address, 0x7B8 clean by set/way, 0x7BC clean by way mask, 0x7F0 clean-and-invalidate by address, 0x7F8 clean-and-invalidate by set/way. A write to any other offset starts nothing.
- R3: Clean issues one write-back only if the line is valid and dirty. Afterwards the dirty bit is 0 and the valid bit is unchanged.
- R4: Clean-and-invalidate issues one write-back if the line is valid and dirty. Afterwards both the valid and dirty bits are 0.
- R5: Invalidate by way clears the valid bit of every line in the masked ways, issues no write-back and leaves dirty bits unchanged. With mask 4'b1111 every line of the cache becomes invalid.
- R6: An address command takes the set from data bits [8:5] and the tag from bits [31:9], and compares the tag against every valid way of that set. On a miss the command ends with no state change and no write-back.
- R7: A set/way command takes the way from data bits [31:30] and the set from bits [8:5].
- R8: A way-mask command takes the mask from data bits [3:0], bit n selecting way n. It visits sets in ascending order and ways in ascending order within each set, and issues its write-backs in that order.
- R9: wb_valid_o stays high with a stable wb_addr_o until wb_ready_i is high, and then drops for at least one cycle. The address is {tag, set, 5'b0}.
- R10: During a way-mask command lock_mask_o equals the mask. During a line command it is all ones, and it is zero when the engine is idle.
- R11: An allocation to a way whose lock bit is set is refused: alloc_ok_o is low and the line does not change. An allocation to an unlocked way is accepted, even in a cycle where the scan is running.
- R12: While a way-mask command runs, reading its own offset returns the mask; any other read returns zero.
- R13: While busy is high, a register write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register offset for writes and reads |
| reg_wdata_i | input | 32 | Command word |
| reg_rdata_o | output | 32 | Read data (active way mask) |
| reg_busy_o | output | 1 | A command is in progress |
| alloc_valid_i | input | 1 | Fill request |
| alloc_set_i | input | 4 | Fill set |
| alloc_way_i | input | 2 | Fill way |
| alloc_tag_i | input | 23 | Fill tag |
| alloc_dirty_i | input | 1 | Fill marks line dirty |
| alloc_ok_o | output | 1 | Fill accepted this cycle |
| lock_mask_o | output | 4 | Ways closed to allocation |
| wb_valid_o | output | 1 | Write-back request |
| wb_addr_o | output | 32 | Write-back line address |
| wb_ready_i | input | 1 | Write-back accepted |
| probe_set_i | input | 4 | Probe set |
| probe_way_i | input | 2 | Probe way |
| probe_valid_o | output | 1 | Probed line valid |
| probe_dirty_o | output | 1 | Probed line dirty |
| probe_tag_o | output | 23 | Probed line tag |

## Verification
A background way scan and a line fill can both change the tag store in the same cycle. The bench starts a clean over ways 0 and 1 with the write-back port throttled, so the scan stays busy for a long time. While the scan is stalled on a write-back, the bench fills way 2 of a set and, in the next cycle, tries to fill way 0 of the same set. The result is judged from alloc_ok_o and from the probe after the scan ends: the fill to way 2 must be present, the refused fill must have left way 0 unchanged, and the scoreboard must have received exactly the predicted write-back sequence.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  typedef enum logic [1:0] {OP_CLEAN, OP_INV, OP_CINV} op_kind_e;
  typedef enum logic [1:0] {TGT_PA, TGT_SW, TGT_WAY} tgt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_STEP, ST_WB} st_e;

  localparam logic [11:0] OFS_INV_WAY  = 12'h77C;
  localparam logic [11:0] OFS_CLN_PA   = 12'h7B0;
  localparam logic [11:0] OFS_CLN_SW   = 12'h7B8;
  localparam logic [11:0] OFS_CLN_WAY  = 12'h7BC;
  localparam logic [11:0] OFS_CINV_PA  = 12'h7F0;
  localparam logic [11:0] OFS_CINV_SW  = 12'h7F8;
endpackage

// File: rtl/cmo_reg_decode.sv
module cmo_reg_decode
  import cmo_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 4,
  parameter int WAY_W    = 2,
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = ADDR_W - INDEX_W - OFFSET_W
) (
  input  logic                we_i,
  input  logic [11:0]         ofs_i,
  input  logic [ADDR_W-1:0]   wdata_i,
  output logic                cmd_o,
  output op_kind_e            kind_o,
  output tgt_e                tgt_o,
  output logic [INDEX_W-1:0]  set_o,
  output logic [WAY_W-1:0]    way_o,
  output logic [TAG_W-1:0]    tag_o,
  output logic [NUM_WAYS-1:0] mask_o
);
  always_comb begin
    cmd_o  = we_i;
    kind_o = OP_CLEAN;
    tgt_o  = TGT_PA;
    unique case (ofs_i)
      OFS_INV_WAY: begin kind_o = OP_INV;   tgt_o = TGT_WAY; end
      OFS_CLN_PA:  begin kind_o = OP_CLEAN; tgt_o = TGT_PA;  end
      OFS_CLN_SW:  begin kind_o = OP_CLEAN; tgt_o = TGT_SW;  end
      OFS_CLN_WAY: begin kind_o = OP_CLEAN; tgt_o = TGT_WAY; end
      OFS_CINV_PA: begin kind_o = OP_CINV;  tgt_o = TGT_PA;  end
      OFS_CINV_SW: begin kind_o = OP_CINV;  tgt_o = TGT_SW;  end
      default:     cmd_o = 1'b0;
    endcase
  end

  assign set_o  = wdata_i[OFFSET_W +: INDEX_W];
  assign way_o  = wdata_i[ADDR_W-1 -: WAY_W];
  assign tag_o  = wdata_i[ADDR_W-1 -: TAG_W];
  assign mask_o = wdata_i[NUM_WAYS-1:0];
endmodule

// File: rtl/cmo_tag_store.sv
module cmo_tag_store #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int INDEX_W  = 4,
  parameter int WAY_W    = 2,
  parameter int TAG_W    = 23
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             alloc_en_i,
  input  logic [INDEX_W-1:0]               alloc_set_i,
  input  logic [WAY_W-1:0]                 alloc_way_i,
  input  logic [TAG_W-1:0]                 alloc_tag_i,
  input  logic                             alloc_dirty_i,
  input  logic                             upd_en_i,
  input  logic [INDEX_W-1:0]               upd_set_i,
  input  logic [WAY_W-1:0]                 upd_way_i,
  input  logic                             upd_clr_valid_i,
  input  logic                             upd_clr_dirty_i,
  input  logic [INDEX_W-1:0]               rd_set_i,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]   rd_tag_o,
  output logic [NUM_WAYS-1:0]              rd_valid_o,
  output logic [NUM_WAYS-1:0]              rd_dirty_o,
  input  logic [INDEX_W-1:0]               probe_set_i,
  input  logic [WAY_W-1:0]                 probe_way_i,
  output logic                             probe_valid_o,
  output logic                             probe_dirty_o,
  output logic [TAG_W-1:0]                 probe_tag_o
);
  logic [NUM_SETS-1:0][NUM_WAYS-1:0]             v_all, d_all;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0]  t_all;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic             v_q, d_q;
      logic [TAG_W-1:0] t_q;
      logic             hit_alloc, hit_upd;

      assign hit_alloc = alloc_en_i && alloc_set_i == INDEX_W'(s) && alloc_way_i == WAY_W'(w);
      assign hit_upd   = upd_en_i && upd_set_i == INDEX_W'(s) && upd_way_i == WAY_W'(w);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q <= 1'b0;
          d_q <= 1'b0;
          t_q <= '0;
        end else if (hit_alloc) begin
          v_q <= 1'b1;
          d_q <= alloc_dirty_i;
          t_q <= alloc_tag_i;
        end else if (hit_upd) begin
          if (upd_clr_valid_i) v_q <= 1'b0;
          if (upd_clr_dirty_i) d_q <= 1'b0;
        end
      end

      assign v_all[s][w] = v_q;
      assign d_all[s][w] = d_q;
      assign t_all[s][w] = t_q;
    end
  end

  assign rd_valid_o    = v_all[rd_set_i];
  assign rd_dirty_o    = d_all[rd_set_i];
  assign rd_tag_o      = t_all[rd_set_i];
  assign probe_valid_o = v_all[probe_set_i][probe_way_i];
  assign probe_dirty_o = d_all[probe_set_i][probe_way_i];
  assign probe_tag_o   = t_all[probe_set_i][probe_way_i];
endmodule

// File: rtl/cmo_sequencer.sv
module cmo_sequencer
  import cmo_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 4,
  parameter int WAY_W    = 2,
  parameter int TAG_W    = 23,
  parameter int ADDR_W   = TAG_W + INDEX_W + OFFSET_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cmd_i,
  input  op_kind_e                       kind_i,
  input  tgt_e                           tgt_i,
  input  logic [INDEX_W-1:0]             set_i,
  input  logic [WAY_W-1:0]               way_i,
  input  logic [TAG_W-1:0]               tag_i,
  input  logic [NUM_WAYS-1:0]            mask_i,
  output logic [INDEX_W-1:0]             rd_set_o,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag_i,
  input  logic [NUM_WAYS-1:0]            rd_valid_i,
  input  logic [NUM_WAYS-1:0]            rd_dirty_i,
  output logic                           upd_en_o,
  output logic [INDEX_W-1:0]             upd_set_o,
  output logic [WAY_W-1:0]               upd_way_o,
  output logic                           upd_clr_valid_o,
  output logic                           upd_clr_dirty_o,
  output logic                           wb_valid_o,
  output logic [ADDR_W-1:0]              wb_addr_o,
  input  logic                           wb_ready_i,
  output logic                           busy_o,
  output logic                           scan_o,
  output op_kind_e                       kind_o,
  output logic [NUM_WAYS-1:0]            lock_mask_o
);
  st_e                 st_q;
  op_kind_e            kind_q;
  logic                scan_q;
  logic [INDEX_W-1:0]  set_q;
  logic [WAY_W-1:0]    way_q;
  logic [TAG_W-1:0]    tag_q;
  logic [NUM_WAYS-1:0] mask_q;

  logic [NUM_WAYS-1:0] hit_vec;
  logic [WAY_W-1:0]    hit_way;
  logic                sel, need_wb, last, pair_done;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      hit_vec[w] = rd_valid_i[w] && rd_tag_i[w] == tag_q;
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign sel       = scan_q ? mask_q[way_q] : 1'b1;
  assign need_wb   = sel && kind_q != OP_INV && rd_valid_i[way_q] && rd_dirty_i[way_q];
  assign last      = !scan_q || (set_q == INDEX_W'(NUM_SETS-1) && way_q == WAY_W'(NUM_WAYS-1));
  assign pair_done = (st_q == ST_STEP && !need_wb) || (st_q == ST_WB && wb_ready_i);

  assign rd_set_o        = set_q;
  assign upd_en_o        = pair_done && sel;
  assign upd_set_o       = set_q;
  assign upd_way_o       = way_q;
  assign upd_clr_dirty_o = kind_q != OP_INV;
  assign upd_clr_valid_o = kind_q != OP_CLEAN;
  assign wb_valid_o      = st_q == ST_WB;
  assign wb_addr_o       = {rd_tag_i[way_q], set_q, OFFSET_W'(0)};
  assign busy_o          = st_q != ST_IDLE;
  assign scan_o          = scan_q;
  assign kind_o          = kind_q;
  assign lock_mask_o     = (st_q == ST_IDLE) ? '0 : (scan_q ? mask_q : '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      kind_q <= OP_CLEAN;
      scan_q <= 1'b0;
      set_q  <= '0;
      way_q  <= '0;
      tag_q  <= '0;
      mask_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cmd_i) begin
          kind_q <= kind_i;
          tag_q  <= tag_i;
          mask_q <= mask_i;
          unique case (tgt_i)
            TGT_PA:  begin set_q <= set_i; scan_q <= 1'b0; st_q <= ST_LOOKUP; end
            TGT_SW:  begin set_q <= set_i; way_q <= way_i; scan_q <= 1'b0; st_q <= ST_STEP; end
            default: begin set_q <= '0; way_q <= '0; scan_q <= 1'b1; st_q <= ST_STEP; end
          endcase
        end
        ST_LOOKUP: begin
          way_q <= hit_way;
          st_q  <= (|hit_vec) ? ST_STEP : ST_IDLE;
        end
        ST_STEP: if (need_wb) st_q <= ST_WB;
        ST_WB:   if (wb_ready_i) st_q <= ST_STEP;
        default: st_q <= ST_IDLE;
      endcase
      if (pair_done) begin
        if (last) begin
          st_q <= ST_IDLE;
        end else if (way_q == WAY_W'(NUM_WAYS-1)) begin
          way_q <= '0;
          set_q <= set_q + 1'b1;
          st_q  <= ST_STEP;
        end else begin
          way_q <= way_q + 1'b1;
          st_q  <= ST_STEP;
        end
      end
    end
  end
endmodule

// File: rtl/cmo_engine.sv
module cmo_engine
  import cmo_pkg::*;
#(
  parameter int NUM_SETS   = 16,
  parameter int NUM_WAYS   = 4,
  parameter int OFFSET_W   = 5,
  parameter int ADDR_W     = 32,
  localparam int INDEX_W   = $clog2(NUM_SETS),
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int TAG_W     = ADDR_W - INDEX_W - OFFSET_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [11:0]         reg_addr_i,
  input  logic [ADDR_W-1:0]   reg_wdata_i,
  output logic [ADDR_W-1:0]   reg_rdata_o,
  output logic                reg_busy_o,
  input  logic                alloc_valid_i,
  input  logic [INDEX_W-1:0]  alloc_set_i,
  input  logic [WAY_W-1:0]    alloc_way_i,
  input  logic [TAG_W-1:0]    alloc_tag_i,
  input  logic                alloc_dirty_i,
  output logic                alloc_ok_o,
  output logic [NUM_WAYS-1:0] lock_mask_o,
  output logic                wb_valid_o,
  output logic [ADDR_W-1:0]   wb_addr_o,
  input  logic                wb_ready_i,
  input  logic [INDEX_W-1:0]  probe_set_i,
  input  logic [WAY_W-1:0]    probe_way_i,
  output logic                probe_valid_o,
  output logic                probe_dirty_o,
  output logic [TAG_W-1:0]    probe_tag_o
);
  logic                           cmd;
  op_kind_e                       cmd_kind, run_kind;
  tgt_e                           cmd_tgt;
  logic [INDEX_W-1:0]             cmd_set, rd_set, upd_set;
  logic [WAY_W-1:0]               cmd_way, upd_way;
  logic [TAG_W-1:0]               cmd_tag;
  logic [NUM_WAYS-1:0]            cmd_mask, rd_valid, rd_dirty;
  logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag;
  logic                           upd_en, upd_clr_valid, upd_clr_dirty, scan;
  logic                           own_reg;

  cmo_reg_decode #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W),
    .WAY_W(WAY_W), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)
  ) u_decode (
    .we_i(reg_we_i), .ofs_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cmd_o(cmd), .kind_o(cmd_kind), .tgt_o(cmd_tgt), .set_o(cmd_set),
    .way_o(cmd_way), .tag_o(cmd_tag), .mask_o(cmd_mask)
  );

  cmo_sequencer #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .OFFSET_W(OFFSET_W),
    .INDEX_W(INDEX_W), .WAY_W(WAY_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .cmd_i(cmd), .kind_i(cmd_kind), .tgt_i(cmd_tgt), .set_i(cmd_set),
    .way_i(cmd_way), .tag_i(cmd_tag), .mask_i(cmd_mask),
    .rd_set_o(rd_set), .rd_tag_i(rd_tag), .rd_valid_i(rd_valid), .rd_dirty_i(rd_dirty),
    .upd_en_o(upd_en), .upd_set_o(upd_set), .upd_way_o(upd_way),
    .upd_clr_valid_o(upd_clr_valid), .upd_clr_dirty_o(upd_clr_dirty),
    .wb_valid_o, .wb_addr_o, .wb_ready_i,
    .busy_o(reg_busy_o), .scan_o(scan), .kind_o(run_kind), .lock_mask_o
  );

  // fills never touch a locked way, so they cannot collide with the engine
  assign alloc_ok_o = alloc_valid_i && !lock_mask_o[alloc_way_i];

  cmo_tag_store #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .INDEX_W(INDEX_W),
    .WAY_W(WAY_W), .TAG_W(TAG_W)
  ) u_store (
    .clk_i, .rst_ni,
    .alloc_en_i(alloc_ok_o), .alloc_set_i, .alloc_way_i, .alloc_tag_i, .alloc_dirty_i,
    .upd_en_i(upd_en), .upd_set_i(upd_set), .upd_way_i(upd_way),
    .upd_clr_valid_i(upd_clr_valid), .upd_clr_dirty_i(upd_clr_dirty),
    .rd_set_i(rd_set), .rd_tag_o(rd_tag), .rd_valid_o(rd_valid), .rd_dirty_o(rd_dirty),
    .probe_set_i, .probe_way_i, .probe_valid_o, .probe_dirty_o, .probe_tag_o
  );

  assign own_reg = (reg_addr_i == OFS_INV_WAY && run_kind == OP_INV) ||
                   (reg_addr_i == OFS_CLN_WAY && run_kind == OP_CLEAN);
  assign reg_rdata_o = (reg_busy_o && scan && own_reg) ? ADDR_W'(lock_mask_o) : '0;
endmodule

// File: rtl/cmo_engine_chk.sv
module cmo_engine_chk #(
  parameter int NUM_WAYS = 4,
  parameter int ADDR_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_busy_o,
  input logic [ADDR_W-1:0]   reg_rdata_o,
  input logic [NUM_WAYS-1:0] lock_mask_o,
  input logic                wb_valid_o,
  input logic [ADDR_W-1:0]   wb_addr_o,
  input logic                wb_ready_i
);
  AST_IDLE_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_busy_o |-> (lock_mask_o == '0 && !wb_valid_o)); // R10

  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o))); // R9

  AST_WB_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && wb_ready_i) |=> !wb_valid_o); // R9

  AST_LOCK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_busy_o && $past(reg_busy_o)) |-> $stable(lock_mask_o)); // R10

  AST_READ_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_busy_o |-> reg_rdata_o == '0); // R12
endmodule

bind cmo_engine cmo_engine_chk #(.NUM_WAYS(NUM_WAYS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .reg_busy_o, .reg_rdata_o, .lock_mask_o,
  .wb_valid_o, .wb_addr_o, .wb_ready_i
);

// File: tb/cmo_engine_tb.sv
module cmo_engine_tb;
  localparam int NS = 16, NW = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        busy;
  logic        alloc_valid = 1'b0, alloc_dirty = 1'b0, alloc_ok;
  logic [3:0]  alloc_set = '0, probe_set = '0, lock_mask;
  logic [1:0]  alloc_way = '0, probe_way = '0;
  logic [22:0] alloc_tag = '0, probe_tag;
  logic        wb_valid, wb_ready = 1'b1, probe_valid, probe_dirty;
  logic [31:0] wb_addr;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit stall_en = 1'b0;
  bit mv [NS][NW];
  bit md [NS][NW];
  int mt [NS][NW];
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  cmo_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .reg_busy_o(busy),
    .alloc_valid_i(alloc_valid), .alloc_set_i(alloc_set), .alloc_way_i(alloc_way),
    .alloc_tag_i(alloc_tag), .alloc_dirty_i(alloc_dirty), .alloc_ok_o(alloc_ok),
    .lock_mask_o(lock_mask), .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .wb_ready_i(wb_ready),
    .probe_set_i(probe_set), .probe_way_i(probe_way),
    .probe_valid_o(probe_valid), .probe_dirty_o(probe_dirty), .probe_tag_o(probe_tag)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] line_addr(int tag, int s);
    return 32'((tag << 9) | (s << 5));
  endfunction

  task automatic reg_write(logic [11:0] ofs, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ofs; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic probe_line(string req, int s, int w);
    probe_set = 4'(s); probe_way = 2'(w);
    #1;
    chk(req, $sformatf("valid s%0d w%0d", s, w), probe_valid, mv[s][w]);
    chk(req, $sformatf("dirty s%0d w%0d", s, w), probe_dirty, md[s][w]);
    if (mv[s][w]) chk(req, $sformatf("tag s%0d w%0d", s, w), probe_tag, mt[s][w]);
  endtask

  // write-back handshake driver
  initial forever begin
    @(posedge clk); #3;
    cyc++;
    wb_ready = !stall_en || (cyc % 3 == 0);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wb_valid && wb_ready) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 unexpected write-back: actual %0h expected none", wb_addr);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (wb_addr != e) begin
          n_fail++;
          $display("FAIL R8 write-back order: actual %0h expected %0h", wb_addr, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected idle");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "wb_valid", wb_valid, 0);
    chk("R1", "lock", lock_mask, 0);
    reg_addr = 12'h7BC; #1;
    chk("R1", "rdata", reg_rdata, 0);
    reg_addr = '0;
    probe_line("R1", 0, 0);

    // fill every line
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        @(negedge clk);
        alloc_valid = 1'b1; alloc_set = 4'(s); alloc_way = 2'(w);
        mt[s][w] = 'h100 + s*4 + w; md[s][w] = ((s ^ w) & 1) != 0; mv[s][w] = 1'b1;
        alloc_tag = 23'(mt[s][w]); alloc_dirty = md[s][w];
      end
    @(negedge clk); alloc_valid = 1'b0;

    // R2 unknown offset starts nothing
    reg_write(12'h7B4, line_addr(mt[3][0], 3));
    chk("R2", "busy after stray write", busy, 0);

    // R3 R6 clean by address, dirty hit
    exp_q.push_back(line_addr(mt[3][0], 3)); md[3][0] = 1'b0;
    reg_write(12'h7B0, line_addr(mt[3][0], 3)); wait_idle();
    probe_line("R3", 3, 0);
    // R3 clean hit on clean line: no write-back
    reg_write(12'h7B0, line_addr(mt[3][1], 3)); wait_idle();
    probe_line("R3", 3, 1);
    // R6 miss: no effect
    reg_write(12'h7F0, line_addr('h7FFFF, 2)); wait_idle();
    chk("R6", "busy after miss", busy, 0);
    probe_line("R6", 2, 1);

    stall_en = 1'b1;
    // R4 R7 clean-and-invalidate by set/way
    exp_q.push_back(line_addr(mt[4][1], 4)); mv[4][1] = 1'b0; md[4][1] = 1'b0;
    reg_write(12'h7F8, (32'd1 << 30) | (32'd4 << 5)); wait_idle();
    probe_line("R4", 4, 1);
    // R7 clean by set/way
    exp_q.push_back(line_addr(mt[6][3], 6)); md[6][3] = 1'b0;
    reg_write(12'h7B8, (32'd3 << 30) | (32'd6 << 5)); wait_idle();
    probe_line("R7", 6, 3);

    // R8 clean ways 0 and 1 in the background
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 2; w++)
        if (mv[s][w] && md[s][w]) begin
          exp_q.push_back(line_addr(mt[s][w], s));
          md[s][w] = 1'b0;
        end
    reg_write(12'h7BC, 32'h3);
    chk("R10", "lock during scan", lock_mask, 4'h3);
    reg_addr = 12'h7BC; #1;
    chk("R12", "readback own reg", reg_rdata, 3);
    reg_addr = 12'h77C; #1;
    chk("R12", "readback other reg", reg_rdata, 0);
    reg_addr = '0;
    // R13 write while busy is ignored
    reg_write(12'h7F8, (32'd3 << 30) | (32'd8 << 5));
    // R11 fill unlocked way concurrently, locked way refused
    @(negedge clk);
    alloc_valid = 1'b1; alloc_set = 4'd5; alloc_way = 2'd2; alloc_tag = 23'h3AB; alloc_dirty = 1'b1;
    #1 chk("R11", "unlocked fill accepted", alloc_ok, 1);
    mt[5][2] = 'h3AB; md[5][2] = 1'b1; mv[5][2] = 1'b1;
    @(negedge clk);
    alloc_way = 2'd0; alloc_tag = 23'h3CD;
    #1 chk("R11", "locked fill refused", alloc_ok, 0);
    @(negedge clk); alloc_valid = 1'b0;
    chk("R13", "still busy", busy, 1);
    wait_idle();
    chk("R10", "lock after scan", lock_mask, 0);
    reg_addr = 12'h7BC; #1;
    chk("R12", "readback after done", reg_rdata, 0);
    reg_addr = '0;
    probe_line("R13", 8, 3);
    probe_line("R11", 5, 2);
    probe_line("R11", 5, 0);
    probe_line("R8", 9, 1);
    chk("R8", "queue drained", exp_q.size(), 0);

    // R5 invalidate every way
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) mv[s][w] = 1'b0;
    reg_write(12'h77C, 32'hF); wait_idle();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) probe_line("R5", s, w);
    chk("R5", "no write-back", exp_q.size(), 0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule